// File: doc/BRIEF.md
# Card Slot Detect and Interrupt Controller

This block sits beside a removable flash card slot and turns the raw slot signals into events that software can use. The card-detect line is synchronized and debounced in hardware. A rising edge of the debounced presence records an insertion event, and a falling edge records a removal event. Each event stays latched until software clears it. The write-protect and ready/busy lines are synchronized and shown, together with the debounced presence, in a read-only slot status register. Two further event sources have no fixed meaning and arrive on generic spare inputs.

Software programs an enable register. It normally arms only the event opposite to the current slot state, so it enables removal while a card is in the slot and insertion while the slot is empty. A single interrupt line is asserted when a latched event that can be reported meets its enable bit, and the global enable bit is set. To acknowledge events, software reads the event register and writes the value back. Only bits inside the report mask can be read or cleared.

Top module: `card_slot_irq`

## Requirements
- R1: After a synchronous reset, the slot status, event and enable registers all read 0x00 and `irq` is low.
- R2: The slot status register (address 0) shows the write-protect input on bit 1, the debounced card presence on bit 2 and the ready/busy input on bit 7. Each input first passes through a two-flop synchronizer. All other bits read 0.
- R3: A change of the synchronized card-detect level takes effect only after it has held for DEB_CYCLES consecutive clocks. A pulse that lasts DEB_CYCLES-1 clocks changes neither the presence bit nor the event register.
- R4: A debounced rise of presence sets event bit 3 (value 0x08, insertion). A debounced fall sets event bit 2 (value 0x04, removal). Both bits stay set until they are cleared.
- R5: A pulse on `spare_evt[0]` sets event bit 0 (0x01), and a pulse on `spare_evt[1]` sets event bit 4 (0x10).
- R6: The event register (address 1) reports and clears only the bits inside mask 0x1D. A write clears each bit that is 1 both in the written data and in the mask. Bits outside the mask always read 0 and a write to them has no effect.
- R7: When an event sets a bit in the same clock as a write that clears it, the bit stays set.
- R8: `irq` is high exactly when enable bit 7 (global) is set and at least one bit of (events & enables & 0x1D) is set. `irq` is registered, so it follows the registers one clock later.
- R9: The enable register (address 2) accepts and reads back all 8 written bits.
- R10: A write to address 0 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cd_raw | input | 1 | Asynchronous card-detect level, 1 = card in slot |
| wp_raw | input | 1 | Asynchronous write-protect level |
| busy_raw | input | 1 | Asynchronous card busy level |
| spare_evt | input | 2 | Synchronous one-clock event pulses for bits 0 and 4 |
| reg_addr | input | 2 | Register address: 0 slot status, 1 events, 2 enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, for the address of the previous clock |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `rst` is held for at least one clock and that `spare_evt` and the register bus inputs are synchronous to `clk`. Only the three raw slot lines may change at any time. The bench drives all of its inputs on the falling edge, so the synchronous inputs always meet this assumption. It moves the card-detect line either for a deliberately short glitch or for long enough to get through the synchronizer and the debounce window. The clear-while-set case is produced by holding a spare pulse high across an acknowledge write.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int REG_W = 8;

  // slot status register bits
  localparam int ST_WP   = 1;
  localparam int ST_PRES = 2;
  localparam int ST_BUSY = 7;

  // event register bits
  localparam int EV_SP0 = 0;
  localparam int EV_REM = 2;
  localparam int EV_INS = 3;
  localparam int EV_SP1 = 4;

  // enable register global bit
  localparam int EN_GLOBAL = 7;

  localparam logic [REG_W-1:0] EV_MASK = 8'h1D;

  typedef enum logic [1:0] {
    A_SLOT = 2'd0,
    A_EVT  = 2'd1,
    A_ENA  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce #(
  parameter int DEB_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      q    <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (din == q) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        cnt  <= '0;
        q    <= din;
        rise <= din;
        fall <= ~din;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the level only moves once the window count is complete
  p_hold_window_r3: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> ($past(cnt) == LIM));

  // R4: an edge pulse always coincides with the matching new level
  p_rise_level_r4: assert property (@(posedge clk) disable iff (rst)
    rise |-> (q && !fall));
endmodule

// File: rtl/cd_event_regs.sv
module cd_event_regs
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_pulse,
  input  logic             rem_pulse,
  input  logic [1:0]       spare_evt,
  input  logic             wr_evt,
  input  logic             wr_ena,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] evt_o,
  output logic [REG_W-1:0] ena_o,
  output logic             irq_o
);
  logic [REG_W-1:0] evt_q, ena_q, set_v, clr_v;
  logic             irq_q;

  always_comb begin
    set_v         = '0;
    set_v[EV_INS] = ins_pulse;
    set_v[EV_REM] = rem_pulse;
    set_v[EV_SP0] = spare_evt[0];
    set_v[EV_SP1] = spare_evt[1];
    clr_v         = wr_evt ? (wdata & EV_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      ena_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= ((evt_q & ~clr_v) | set_v) & EV_MASK;
      if (wr_ena) ena_q <= wdata;
      irq_q <= ena_q[EN_GLOBAL] && (|(evt_q & ena_q & EV_MASK));
    end
  end

  assign evt_o = evt_q;
  assign ena_o = ena_q;
  assign irq_o = irq_q;

  // R4: insertion event is sticky until a clear hits it
  p_ins_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_q[EV_INS] && !clr_v[EV_INS]) |=> evt_q[EV_INS]);

  // R7: a set in the same clock as a clear wins
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_pulse && clr_v[EV_INS]) |=> evt_q[EV_INS]);

  // R8: no interrupt without the global enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !ena_q[EN_GLOBAL] |=> !irq_q);

  // R8: pending enabled event with global enable raises the line
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (ena_q[EN_GLOBAL] && |(evt_q & ena_q & EV_MASK)) |=> irq_q);
endmodule

// File: rtl/card_slot_irq.sv
module card_slot_irq
  import card_irq_pkg::*;
#(
  parameter int DEB_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cd_raw,
  input  logic             wp_raw,
  input  logic             busy_raw,
  input  logic [1:0]       spare_evt,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_v, sync_v;
  logic             pres, ins_p, rem_p;
  logic [REG_W-1:0] slot_v, evt_v, ena_v, rd_q;
  logic             wr_evt, wr_ena;

  assign raw_v = {busy_raw, wp_raw, cd_raw};

  cd_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(sync_v)
  );

  cd_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst(rst), .din(sync_v[0]),
    .q(pres), .rise(ins_p), .fall(rem_p)
  );

  assign wr_evt = reg_wr && (reg_addr == A_EVT);
  assign wr_ena = reg_wr && (reg_addr == A_ENA);

  cd_event_regs u_evt (
    .clk(clk), .rst(rst),
    .ins_pulse(ins_p), .rem_pulse(rem_p), .spare_evt(spare_evt),
    .wr_evt(wr_evt), .wr_ena(wr_ena), .wdata(reg_wdata),
    .evt_o(evt_v), .ena_o(ena_v), .irq_o(irq)
  );

  always_comb begin
    slot_v          = '0;
    slot_v[ST_WP]   = sync_v[1];
    slot_v[ST_PRES] = pres;
    slot_v[ST_BUSY] = sync_v[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (reg_addr)
        A_SLOT:  rd_q <= slot_v;
        A_EVT:   rd_q <= evt_v & EV_MASK;
        A_ENA:   rd_q <= ena_v;
        default: rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_q;

  // R6: event reads never show bits outside the report mask
  p_evt_read_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_EVT) |=> ((reg_rdata & ~EV_MASK) == '0));

  // R2: slot status reads keep unused bits at zero
  p_slot_read_clean_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_SLOT) |=> ((reg_rdata & 8'h79) == '0));
endmodule

// File: tb/card_slot_irq_tb.sv
module card_slot_irq_tb;
  localparam int DEB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cd_raw = 1'b0, wp_raw = 1'b0, busy_raw = 1'b0;
  logic [1:0] spare_evt = 2'b00;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  card_slot_irq #(.DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst(rst), .cd_raw(cd_raw), .wp_raw(wp_raw),
    .busy_raw(busy_raw), .spare_evt(spare_evt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_spare(input logic [1:0] v);
    @(negedge clk); spare_evt = v;
    @(negedge clk); spare_evt = 2'b00;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 slot", v, 8'h00);
    rd(2'd1, v); chk("R1 events", v, 8'h00);
    rd(2'd2, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_slot_bits;
    logic [7:0] v;
    @(negedge clk); wp_raw = 1'b1; busy_raw = 1'b1;
    idle(4);
    rd(2'd0, v); chk("R2 wp+busy", v, 8'h82);
    @(negedge clk); wp_raw = 1'b0;
    idle(4);
    rd(2'd0, v); chk("R2 busy only", v, 8'h80);
    @(negedge clk); busy_raw = 1'b0;
    idle(4);
    rd(2'd0, v); chk("R2 clear", v, 8'h00);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    @(negedge clk); cd_raw = 1'b1;
    idle(DEB - 1);
    cd_raw = 1'b0;
    idle(DEB + 8);
    rd(2'd1, v); chk("R3 short pulse no event", v, 8'h00);
    rd(2'd0, v); chk("R3 short pulse no presence", v, 8'h00);
  endtask

  task automatic t_insert;
    logic [7:0] v;
    @(negedge clk); cd_raw = 1'b1;
    idle(DEB + 6);
    rd(2'd1, v); chk("R4 insert event", v, 8'h08);
    rd(2'd0, v); chk("R2 presence bit", v, 8'h04);
    idle(20);
    rd(2'd1, v); chk("R4 insert sticky", v, 8'h08);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R6 insert acked", v, 8'h00);
  endtask

  task automatic t_remove;
    logic [7:0] v;
    @(negedge clk); cd_raw = 1'b0;
    idle(DEB + 6);
    rd(2'd1, v); chk("R4 remove event", v, 8'h04);
    rd(2'd0, v); chk("R2 presence gone", v, 8'h00);
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R6 remove acked", v, 8'h00);
  endtask

  task automatic t_spare;
    logic [7:0] v;
    pulse_spare(2'b01);
    rd(2'd1, v); chk("R5 spare0", v, 8'h01);
    pulse_spare(2'b10);
    rd(2'd1, v); chk("R5 spare1", v, 8'h11);
    wr(2'd1, 8'h11);
    rd(2'd1, v); chk("R6 spares acked", v, 8'h00);
  endtask

  task automatic t_ack_mask;
    logic [7:0] v;
    pulse_spare(2'b01);
    wr(2'd1, 8'hFE);
    rd(2'd1, v); chk("R6 other bits keep spare0", v, 8'h01);
    wr(2'd1, 8'hE2);
    rd(2'd1, v); chk("R6 unmasked write no effect", v, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R6 masked clear", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    @(negedge clk); spare_evt = 2'b01;
    reg_addr = 2'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; spare_evt = 2'b00;
    rd(2'd1, v); chk("R7 set beats clear", v, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R7 later clear", v, 8'h00);
  endtask

  task automatic t_irq;
    pulse_spare(2'b01);
    wr(2'd2, 8'h01); idle(2);
    chk("R8 no global", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h81); idle(2);
    chk("R8 global+match", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h90); idle(2);
    chk("R8 enable mismatch", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h81); idle(2);
    wr(2'd1, 8'h01); idle(2);
    chk("R8 cleared by ack", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h88);
    @(negedge clk); cd_raw = 1'b1;
    idle(DEB + 6);
    chk("R8 insert interrupt", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h08); idle(2);
    chk("R8 insert acked", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable_rb;
    logic [7:0] v;
    wr(2'd2, 8'hA5);
    rd(2'd2, v); chk("R9 enable readback", v, 8'hA5);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ro_slot;
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R10 slot unchanged", v, 8'h04);
    rd(2'd1, v); chk("R10 events unchanged", v, 8'h00);
    rd(2'd2, v); chk("R10 enable unchanged", v, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_slot_bits();
    t_glitch();
    t_insert();
    t_remove();
    t_spare();
    t_ack_mask();
    t_set_wins();
    t_irq();
    t_enable_rb();
    t_ro_slot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule